// File: doc/BRIEF.md
# Late Field Merge Queue for a Trace Memory

A trace memory stores one record per traced command as soon as the command is seen. Some commands carry a data phase that arrives later. Fields that can only be known from that data, here a byte-enable union and a beat count, are written as zero when the command record is stored. This block fills them in afterwards. It keeps the trace-memory entry index of every command that announces a data phase, in command order. It folds the data beats of each transfer into one result. When the last beat arrives, it places a patch record `{entry index, beat count, byte-enable union}` in a shallow queue.

The queue asks the memory arbiter for the write port with `patchReq`. A patch is committed (`patchWe`) only in a cycle where the arbiter grants and no command record is being stored. Command records always win the port. The queue never stalls the data stream. When it is full and a new patch arrives with no slot freed in that cycle, the oldest patch is discarded and a sticky flag is raised. The discarded entry then keeps zeros in its late fields.

Top module: `late_merge_fifo`

## Requirements
- R1: After reset, `patchReq`, `patchWe` and `ovfFlag` are 0.
- R2: A patch's `patchMask` is the bitwise OR of `beatMask` over every cycle with `beatValid`=1 in that transfer, the last beat included. `patchLen` is the number of such cycles. Cycles with `beatValid`=0 contribute nothing, whatever `beatMask` holds.
- R3: `patchLen` (LEN_W=4 bits) saturates at 15 when a transfer has more beats than that.
- R4: Transfers are matched to commands in order. The n-th transfer's patch carries the `cmdIdx` of the n-th command that had `cmdValid`=1 and `cmdHasData`=1. A command with `cmdHasData`=0 never produces a patch.
- R5: After the clock edge that samples a beat with `beatValid`=1 and `beatLast`=1, `patchReq` is 1. `patchReq` stays 1 while any patch is queued.
- R6: `patchWe` = `patchReq` AND `patchGnt` AND NOT `cmdValid`. A patch that is not written stays at the head with unchanged fields, even if its data ended while the port was busy.
- R7: Patches leave the queue in the order in which their transfers completed, and the queue holds at most FIFO_DEPTH (default 4) patches.
- R8: If a patch arrives while the queue is full and none is written in that cycle, the oldest patch is discarded and never written. `ovfFlag` becomes 1 and stays 1 until reset.
- R9: If a patch arrives while the queue is full and the head is written in that same cycle, no patch is lost and `ovfFlag` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command record is stored this cycle (trace-memory port busy) |
| cmdHasData | input | 1 | The command has a later data phase |
| cmdIdx | input | IDX_W (6) | Trace-memory entry index of the command record |
| beatValid | input | 1 | Data beat present |
| beatLast | input | 1 | Final beat of the transfer |
| beatMask | input | MASK_W (8) | Byte enables of the beat |
| patchGnt | input | 1 | Arbiter grant for the trace-memory write port |
| patchReq | output | 1 | A patch is waiting |
| patchWe | output | 1 | Patch written to the trace memory this cycle |
| patchIdx | output | IDX_W (6) | Entry index to patch |
| patchLen | output | LEN_W (4) | Beat count to write |
| patchMask | output | MASK_W (8) | Byte-enable union to write |
| ovfFlag | output | 1 | Sticky: at least one patch was discarded |

## Verification
The assertions assume three things about the inputs. No data beat arrives unless an earlier command with a data phase is still waiting for its transfer. At most TAG_DEPTH such commands wait at once. A transfer's first beat comes no earlier than the cycle after its command.

The stimulus meets these assumptions by construction. Each command is driven on its own cycle, its beats follow in later cycles, and no more than two commands are ever outstanding together. Within those limits, the grant and `cmdValid` are driven freely. This covers the port-conflict, hold and overflow cases.

// File: rtl/lmf_pkg.sv
package lmf_pkg;

  // Strobes from the control to the datapath, one per storage action.
  typedef struct packed {
    logic tagPush;   // store the index of a command that has data
    logic tagPop;    // transfer finished, release its index
    logic accStep;   // fold a non-final beat into the accumulator
    logic accClear;  // final beat: accumulator restarts
    logic updPush;   // write the finished patch into the queue
    logic updPop;    // head patch committed to the trace memory
  } lmf_strobe_t;

endpackage

// File: rtl/lmf_ctrl.sv
module lmf_ctrl
  import lmf_pkg::*;
#(
  parameter int TAG_DEPTH  = 4,
  parameter int FIFO_DEPTH = 4,
  localparam int TAG_PTR_W  = (TAG_DEPTH  > 1) ? $clog2(TAG_DEPTH)  : 1,
  localparam int FIFO_PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdValid,
  input  logic                  cmdHasData,
  input  logic                  beatValid,
  input  logic                  beatLast,
  input  logic                  patchGnt,
  output lmf_strobe_t           stb,
  output logic [TAG_PTR_W-1:0]  tagWrPtr,
  output logic [TAG_PTR_W-1:0]  tagRdPtr,
  output logic [FIFO_PTR_W-1:0] updWrPtr,
  output logic [FIFO_PTR_W-1:0] updRdPtr,
  output logic                  patchReq,
  output logic                  patchWe,
  output logic                  ovfFlag
);

  logic [CNT_W-1:0] updCnt;
  logic             updFull;
  logic             dropOld;
  logic             cntUp;
  logic             cntDn;

  function automatic logic [TAG_PTR_W-1:0] tagNext(input logic [TAG_PTR_W-1:0] p);
    return (p == TAG_PTR_W'(TAG_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [FIFO_PTR_W-1:0] updNext(input logic [FIFO_PTR_W-1:0] p);
    return (p == FIFO_PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign updFull  = (updCnt == CNT_W'(FIFO_DEPTH));
  assign patchReq = (updCnt != '0);
  // Command records own the port; a grant during one is not used.
  assign patchWe  = patchReq && patchGnt && !cmdValid;

  always_comb begin
    stb          = '0;
    stb.tagPush  = cmdValid && cmdHasData;
    stb.tagPop   = beatValid && beatLast;
    stb.accStep  = beatValid && !beatLast;
    stb.accClear = beatValid && beatLast;
    stb.updPush  = beatValid && beatLast;
    stb.updPop   = patchWe;
  end

  // A full queue with no commit this cycle overwrites its oldest slot.
  assign dropOld = stb.updPush && updFull && !stb.updPop;
  assign cntUp   = stb.updPush && !stb.updPop && !updFull;
  assign cntDn   = stb.updPop && !stb.updPush;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagWrPtr <= '0;
      tagRdPtr <= '0;
    end else begin
      if (stb.tagPush) tagWrPtr <= tagNext(tagWrPtr);
      if (stb.tagPop)  tagRdPtr <= tagNext(tagRdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updWrPtr <= '0;
      updRdPtr <= '0;
      updCnt   <= '0;
      ovfFlag  <= 1'b0;
    end else begin
      if (stb.updPush)           updWrPtr <= updNext(updWrPtr);
      if (stb.updPop || dropOld) updRdPtr <= updNext(updRdPtr);
      if (cntUp)                 updCnt   <= updCnt + 1'b1;
      else if (cntDn)            updCnt   <= updCnt - 1'b1;
      if (dropOld)               ovfFlag  <= 1'b1;
    end
  end

endmodule

// File: rtl/lmf_datapath.sv
module lmf_datapath
  import lmf_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int MASK_W     = 8,
  parameter int LEN_W      = 4,
  parameter int TAG_DEPTH  = 4,
  parameter int FIFO_DEPTH = 4,
  localparam int TAG_PTR_W  = (TAG_DEPTH  > 1) ? $clog2(TAG_DEPTH)  : 1,
  localparam int FIFO_PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1,
  localparam int ENT_W      = IDX_W + LEN_W + MASK_W,
  localparam logic [LEN_W-1:0] LEN_MAX = '1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  lmf_strobe_t           stb,
  input  logic [IDX_W-1:0]      cmdIdx,
  input  logic [MASK_W-1:0]     beatMask,
  input  logic [TAG_PTR_W-1:0]  tagWrPtr,
  input  logic [TAG_PTR_W-1:0]  tagRdPtr,
  input  logic [FIFO_PTR_W-1:0] updWrPtr,
  input  logic [FIFO_PTR_W-1:0] updRdPtr,
  output logic [IDX_W-1:0]      patchIdx,
  output logic [LEN_W-1:0]      patchLen,
  output logic [MASK_W-1:0]     patchMask
);

  logic [IDX_W-1:0]  tagView [TAG_DEPTH];
  logic [ENT_W-1:0]  updView [FIFO_DEPTH];
  logic [MASK_W-1:0] accMask;
  logic [LEN_W-1:0]  accLen;
  logic [LEN_W-1:0]  lenInc;
  logic [ENT_W-1:0]  finEntry;
  logic [ENT_W-1:0]  headEntry;

  // Outstanding command indices, in command order.
  for (genvar t = 0; t < TAG_DEPTH; t++) begin : g_tag
    logic [IDX_W-1:0] slotIdx;
    always_ff @(posedge clk) begin
      if (stb.tagPush && tagWrPtr == TAG_PTR_W'(t)) slotIdx <= cmdIdx;
    end
    assign tagView[t] = slotIdx;
  end

  // Beat accumulator; counts saturate instead of wrapping.
  assign lenInc = (accLen == LEN_MAX) ? LEN_MAX : accLen + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accMask <= '0;
      accLen  <= '0;
    end else if (stb.accClear) begin
      accMask <= '0;
      accLen  <= '0;
    end else if (stb.accStep) begin
      accMask <= accMask | beatMask;
      accLen  <= lenInc;
    end
  end

  assign finEntry = {tagView[tagRdPtr], lenInc, accMask | beatMask};

  // Patch queue storage.
  for (genvar s = 0; s < FIFO_DEPTH; s++) begin : g_upd
    logic [ENT_W-1:0] slotEnt;
    always_ff @(posedge clk) begin
      if (stb.updPush && updWrPtr == FIFO_PTR_W'(s)) slotEnt <= finEntry;
    end
    assign updView[s] = slotEnt;
  end

  assign headEntry = updView[updRdPtr];
  assign patchIdx  = headEntry[ENT_W-1 -: IDX_W];
  assign patchLen  = headEntry[MASK_W +: LEN_W];
  assign patchMask = headEntry[MASK_W-1:0];

endmodule

// File: rtl/late_merge_fifo.sv
module late_merge_fifo
  import lmf_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int MASK_W     = 8,
  parameter int LEN_W      = 4,
  parameter int TAG_DEPTH  = 4,
  parameter int FIFO_DEPTH = 4,
  localparam int TAG_PTR_W  = (TAG_DEPTH  > 1) ? $clog2(TAG_DEPTH)  : 1,
  localparam int FIFO_PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdHasData,
  input  logic [IDX_W-1:0]  cmdIdx,
  input  logic              beatValid,
  input  logic              beatLast,
  input  logic [MASK_W-1:0] beatMask,
  input  logic              patchGnt,
  output logic              patchReq,
  output logic              patchWe,
  output logic [IDX_W-1:0]  patchIdx,
  output logic [LEN_W-1:0]  patchLen,
  output logic [MASK_W-1:0] patchMask,
  output logic              ovfFlag
);

  lmf_strobe_t           stb;
  logic [TAG_PTR_W-1:0]  tagWrPtr;
  logic [TAG_PTR_W-1:0]  tagRdPtr;
  logic [FIFO_PTR_W-1:0] updWrPtr;
  logic [FIFO_PTR_W-1:0] updRdPtr;

  lmf_ctrl #(
    .TAG_DEPTH (TAG_DEPTH),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdHasData(cmdHasData),
    .beatValid (beatValid),
    .beatLast  (beatLast),
    .patchGnt  (patchGnt),
    .stb       (stb),
    .tagWrPtr  (tagWrPtr),
    .tagRdPtr  (tagRdPtr),
    .updWrPtr  (updWrPtr),
    .updRdPtr  (updRdPtr),
    .patchReq  (patchReq),
    .patchWe   (patchWe),
    .ovfFlag   (ovfFlag)
  );

  lmf_datapath #(
    .IDX_W     (IDX_W),
    .MASK_W    (MASK_W),
    .LEN_W     (LEN_W),
    .TAG_DEPTH (TAG_DEPTH),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cmdIdx   (cmdIdx),
    .beatMask (beatMask),
    .tagWrPtr (tagWrPtr),
    .tagRdPtr (tagRdPtr),
    .updWrPtr (updWrPtr),
    .updRdPtr (updRdPtr),
    .patchIdx (patchIdx),
    .patchLen (patchLen),
    .patchMask(patchMask)
  );

endmodule

// File: rtl/lmf_checker.sv
module lmf_checker #(
  parameter int IDX_W      = 6,
  parameter int MASK_W     = 8,
  parameter int LEN_W      = 4,
  parameter int FIFO_DEPTH = 4,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              beatValid,
  input logic              beatLast,
  input logic              patchGnt,
  input logic              patchReq,
  input logic              patchWe,
  input logic [IDX_W-1:0]  patchIdx,
  input logic [LEN_W-1:0]  patchLen,
  input logic [MASK_W-1:0] patchMask,
  input logic              ovfFlag,
  input logic [CNT_W-1:0]  updCnt
);

  // R6
  cmd_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(patchWe && cmdValid));

  // R6
  grant_needed_chk: assert property (@(posedge clk) disable iff (!rstN)
    patchWe |-> (patchReq && patchGnt));

  // R6
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (patchReq && !patchWe && !(beatValid && beatLast))
      |=> (patchReq && $stable(patchIdx) && $stable(patchLen) && $stable(patchMask)));

  // R5
  last_beat_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && beatLast) |=> patchReq);

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    updCnt <= CNT_W'(FIFO_DEPTH));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |=> ovfFlag);

  // R9
  full_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updCnt == CNT_W'(FIFO_DEPTH) && patchWe && beatValid && beatLast)
      |=> (ovfFlag == $past(ovfFlag)));

endmodule

bind late_merge_fifo lmf_checker #(
  .IDX_W     (IDX_W),
  .MASK_W    (MASK_W),
  .LEN_W     (LEN_W),
  .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .beatValid(beatValid),
  .beatLast (beatLast),
  .patchGnt (patchGnt),
  .patchReq (patchReq),
  .patchWe  (patchWe),
  .patchIdx (patchIdx),
  .patchLen (patchLen),
  .patchMask(patchMask),
  .ovfFlag  (ovfFlag),
  .updCnt   (u_ctrl.updCnt)
);

// File: tb/late_merge_fifo_tb.sv
module late_merge_fifo_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic       cmdHasData = 1'b0;
  logic [5:0] cmdIdx = '0;
  logic       beatValid = 1'b0;
  logic       beatLast = 1'b0;
  logic [7:0] beatMask = '1;
  logic       patchGnt = 1'b0;
  logic       patchReq;
  logic       patchWe;
  logic [5:0] patchIdx;
  logic [3:0] patchLen;
  logic [7:0] patchMask;
  logic       ovfFlag;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  late_merge_fifo u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdHasData(cmdHasData),
    .cmdIdx    (cmdIdx),
    .beatValid (beatValid),
    .beatLast  (beatLast),
    .beatMask  (beatMask),
    .patchGnt  (patchGnt),
    .patchReq  (patchReq),
    .patchWe   (patchWe),
    .patchIdx  (patchIdx),
    .patchLen  (patchLen),
    .patchMask (patchMask),
    .ovfFlag   (ovfFlag)
  );

  // Vector fields: {gap, beat count, first beat mask, entry index}.
  // Beat i uses the first mask rotated left by i.
  localparam logic [19:0] VECS [6] = '{
    {1'b0, 5'd1,  8'h01, 6'd3},
    {1'b0, 5'd3,  8'h11, 6'd7},
    {1'b1, 5'd2,  8'h80, 6'd63},
    {1'b0, 5'd4,  8'h03, 6'd0},
    {1'b1, 5'd18, 8'h01, 6'd45},
    {1'b0, 5'd8,  8'h00, 6'd21}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendCmd(input logic [5:0] idx, input logic hasData);
    cmdValid = 1'b1; cmdHasData = hasData; cmdIdx = idx;
    @(negedge clk);
    cmdValid = 1'b0; cmdHasData = 1'b0;
  endtask

  task automatic sendBeat(input logic [7:0] m, input logic last);
    beatValid = 1'b1; beatLast = last; beatMask = m;
    @(negedge clk);
    beatValid = 1'b0; beatLast = 1'b0; beatMask = 8'hFF;
  endtask

  task automatic takePatch(input string tag, input logic [5:0] idx,
                           input logic [3:0] len, input logic [7:0] m);
    patchGnt = 1'b1;
    #1;
    chk({tag, " req"}, patchReq, 1'b1);
    chk({tag, " we"}, patchWe, 1'b1);
    chk({tag, " idx"}, patchIdx, idx);
    chk({tag, " len"}, patchLen, len);
    chk({tag, " mask"}, patchMask, m);
    @(negedge clk);
    patchGnt = 1'b0;
  endtask

  function automatic logic [7:0] rotl(input logic [7:0] m, input int n);
    logic [7:0] r = m;
    for (int i = 0; i < n % 8; i++) r = {r[6:0], r[7]};
    return r;
  endfunction

  task automatic finish();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog all-R act=running exp=done");
    finish();
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1 reset state
    #1;
    chk("R1 req", patchReq, 1'b0);
    chk("R1 we", patchWe, 1'b0);
    chk("R1 ovf", ovfFlag, 1'b0);

    // R2 R3 R4: table of transfers
    for (int v = 0; v < 6; v++) begin
      int nb;
      logic [7:0] expMask;
      logic [3:0] expLen;
      nb = int'(VECS[v][18:14]);
      expMask = '0;
      sendCmd(VECS[v][5:0], 1'b1);
      for (int b = 0; b < nb; b++) begin
        expMask |= rotl(VECS[v][13:6], b);
        sendBeat(rotl(VECS[v][13:6], b), b == nb - 1);
        if (VECS[v][19] && b != nb - 1) @(negedge clk);
      end
      expLen = (nb > 15) ? 4'd15 : 4'(nb);
      takePatch("R2 R3 vector", VECS[v][5:0], expLen, expMask);
    end

    // R4 order of two outstanding commands
    sendCmd(6'd40, 1'b1);
    sendCmd(6'd41, 1'b1);
    sendBeat(8'h01, 1'b0);
    sendBeat(8'h02, 1'b1);
    sendBeat(8'h04, 1'b1);
    takePatch("R4 first", 6'd40, 4'd2, 8'h03);
    takePatch("R4 second", 6'd41, 4'd1, 8'h04);

    // R6 command wins the port; R4 no patch from a data-less command
    sendCmd(6'd30, 1'b1);
    cmdValid = 1'b1; cmdHasData = 1'b0; cmdIdx = 6'd9;
    beatValid = 1'b1; beatLast = 1'b1; beatMask = 8'h5A;
    @(negedge clk);
    beatValid = 1'b0; beatLast = 1'b0; beatMask = 8'hFF;
    patchGnt = 1'b1;
    #1;
    chk("R6 busy req", patchReq, 1'b1);
    chk("R6 busy we", patchWe, 1'b0);
    @(negedge clk);
    #1;
    chk("R6 busy we2", patchWe, 1'b0);
    cmdValid = 1'b0;
    patchGnt = 1'b0;
    takePatch("R6 after busy", 6'd30, 4'd1, 8'h5A);
    #1;
    chk("R4 no data no patch", patchReq, 1'b0);

    // R5 request appears after final beat; grant low holds it (R6)
    sendCmd(6'd50, 1'b1);
    sendBeat(8'h20, 1'b1);
    #1;
    chk("R5 req", patchReq, 1'b1);
    chk("R6 no grant we", patchWe, 1'b0);
    @(negedge clk);
    takePatch("R6 held", 6'd50, 4'd1, 8'h20);

    // R8 overflow drops oldest
    for (int k = 0; k < 5; k++) begin
      sendCmd(6'(10 + k), 1'b1);
      sendBeat(8'(1 << k), 1'b1);
    end
    #1;
    chk("R8 ovf set", ovfFlag, 1'b1);
    for (int k = 1; k < 5; k++) takePatch("R7 R8 drain", 6'(10 + k), 4'd1, 8'(1 << k));
    #1;
    chk("R8 empty", patchReq, 1'b0);
    chk("R8 sticky", ovfFlag, 1'b1);

    // R1 reset clears the flag; R9 push and commit together when full
    doReset();
    #1;
    chk("R1 ovf cleared", ovfFlag, 1'b0);
    for (int k = 0; k < 4; k++) begin
      sendCmd(6'(20 + k), 1'b1);
      sendBeat(8'(1 << k), 1'b1);
    end
    sendCmd(6'd24, 1'b1);
    beatValid = 1'b1; beatLast = 1'b1; beatMask = 8'h40;
    patchGnt = 1'b1;
    #1;
    chk("R9 we", patchWe, 1'b1);
    chk("R9 head", patchIdx, 6'd20);
    @(negedge clk);
    beatValid = 1'b0; beatLast = 1'b0; beatMask = 8'hFF; patchGnt = 1'b0;
    for (int k = 1; k < 4; k++) takePatch("R9 drain", 6'(20 + k), 4'd1, 8'(1 << k));
    takePatch("R9 newest", 6'd24, 4'd1, 8'h40);
    #1;
    chk("R9 no ovf", ovfFlag, 1'b0);
    chk("R9 empty", patchReq, 1'b0);

    finish();
  end

endmodule